// File: doc/BRIEF.md
# MIDI Note Tone Generator

This peripheral turns a MIDI note number written by the processor into a square wave on a single speaker pin. Software performs one bus write of the note number to the peripheral's note address. The block looks up the half-period length for that note, measured in system clock cycles, and a divider flips the speaker pin each time that many cycles have passed. The high and low halves of the wave are the same length. Writing 0, or any number outside the supported range, silences the pin and holds it low. The last value written can be read back combinationally.

A small state machine drives the output. Its states are IDLE (silent, pin low), LOW (tone running, pin low) and HIGH (tone running, pin high). Its transitions are as follows:

- IDLE to LOW on a write of a valid note.
- LOW to HIGH when the half-period count expires.
- HIGH to LOW when the half-period count expires.
- LOW or HIGH to IDLE on a write of a silent value.
- LOW to LOW, and HIGH to HIGH, on a write of a valid note. This restarts the count and keeps the present level.

Top module: `tone_gen`

## Requirements
- R1: After reset, spk_out is 0 and rd_data is 0.
- R2: A cycle with wr_en high and wr_addr equal to 0x8024 (bank base 0x8000 plus offset 0x24) stores wr_data[7:0]. From the next cycle, rd_data shows that value zero-extended. Writes to any other address, and cycles with wr_en low, leave rd_data unchanged.
- R3: While a note n in 60..96 is running, spk_out is a square wave. Each high level and each low level lasts exactly H(n) clock cycles. H(n) = round(6,000,000 / (440 * 2^((n-69)/12))), which gives the note's pitch at a 12 MHz clock. For example, H(60)=22934, H(69)=13636 and H(96)=2867.
- R4: When a valid note is written while the block is silent, spk_out stays low. It first rises exactly H(n) cycles after the clock edge that takes the write.
- R5: When a valid note is written while a tone is running, spk_out keeps its present level at that edge. The next toggle comes exactly H(new) cycles after the write edge.
- R6: Writing 0 drives spk_out low from the clock edge that takes the write.
- R7: Any stored value from 1 to 59 or from 97 to 255 acts exactly like 0.
- R8: While silent, spk_out stays constant low until a valid note is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (12 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle bus write strobe |
| wr_addr | input | ADDR_W (16) | Bus write address |
| wr_data | input | DATA_W (32) | Bus write data; only bits 7:0 are kept |
| rd_data | output | DATA_W (32) | Stored note, zero-extended |
| spk_out | output | 1 | Square-wave speaker drive |

## Verification
The properties assume the following about the write inputs: they are known values, they change only between rising edges, and each write lasts one cycle. The bench drives every bus signal on the falling edge and holds wr_en high for a single cycle. A new valid write is issued only when no toggle is due in the same cycle. This ensures that every expected speaker edge is scheduled from one write edge alone. The stimulus covers several cases:
- writes from silence and writes while a tone is running, at both levels;
- the lowest note, the highest note and the note numbers just outside the range;
- a write to a neighbouring address;
- data with bits set above the low byte.

// File: rtl/tone_pkg.sv
`timescale 1ns/1ps
package tone_pkg;
    localparam int NOTE_W  = 8;
    localparam int NOTE_LO = 60;
    localparam int NOTE_HI = 96;
    localparam int HALF_W  = 15;

    typedef enum logic [1:0] {
        TONE_IDLE = 2'd0,
        TONE_LOW  = 2'd1,
        TONE_HIGH = 2'd2
    } tone_state_e;

    function automatic logic note_ok(input logic [NOTE_W-1:0] n);
        return (n >= NOTE_W'(NOTE_LO)) && (n <= NOTE_W'(NOTE_HI));
    endfunction
endpackage

// File: rtl/tone_regs.sv
`timescale 1ns/1ps
module tone_regs
    import tone_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] HIT_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit,
    output logic [NOTE_W-1:0] new_note,
    output logic [NOTE_W-1:0] note_q
);
    logic unused_hi;

    assign hit       = wr_en && (wr_addr == HIT_ADDR);
    assign new_note  = wr_data[NOTE_W-1:0];
    assign unused_hi = ^wr_data[DATA_W-1:NOTE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            note_q <= '0;
        end else if (hit) begin
            note_q <= new_note;
        end
    end
endmodule

// File: rtl/tone_lut.sv
`timescale 1ns/1ps
module tone_lut
    import tone_pkg::*;
(
    input  logic [NOTE_W-1:0] note,
    output logic [HALF_W-1:0] half
);
    always_comb begin
        unique case (note)
            8'd60: half = 15'd22934;
            8'd61: half = 15'd21646;
            8'd62: half = 15'd20431;
            8'd63: half = 15'd19285;
            8'd64: half = 15'd18202;
            8'd65: half = 15'd17181;
            8'd66: half = 15'd16216;
            8'd67: half = 15'd15306;
            8'd68: half = 15'd14447;
            8'd69: half = 15'd13636;
            8'd70: half = 15'd12871;
            8'd71: half = 15'd12149;
            8'd72: half = 15'd11467;
            8'd73: half = 15'd10823;
            8'd74: half = 15'd10216;
            8'd75: half = 15'd9642;
            8'd76: half = 15'd9101;
            8'd77: half = 15'd8590;
            8'd78: half = 15'd8108;
            8'd79: half = 15'd7653;
            8'd80: half = 15'd7224;
            8'd81: half = 15'd6818;
            8'd82: half = 15'd6436;
            8'd83: half = 15'd6074;
            8'd84: half = 15'd5733;
            8'd85: half = 15'd5412;
            8'd86: half = 15'd5108;
            8'd87: half = 15'd4821;
            8'd88: half = 15'd4551;
            8'd89: half = 15'd4295;
            8'd90: half = 15'd4054;
            8'd91: half = 15'd3827;
            8'd92: half = 15'd3612;
            8'd93: half = 15'd3409;
            8'd94: half = 15'd3218;
            8'd95: half = 15'd3037;
            8'd96: half = 15'd2867;
            default: half = '0;
        endcase
    end
endmodule

// File: rtl/tone_div.sv
`timescale 1ns/1ps
module tone_div
    import tone_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_ok,
    input  logic [HALF_W-1:0] half,
    output logic              spk
);
    tone_state_e       state_q, state_d;
    logic [HALF_W-1:0] cnt_q;
    logic              cnt_end;

    assign cnt_end = (cnt_q == half - HALF_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TONE_IDLE: begin
                if (load && load_ok) state_d = TONE_LOW;
            end
            TONE_LOW: begin
                if (load)         state_d = load_ok ? TONE_LOW : TONE_IDLE;
                else if (cnt_end) state_d = TONE_HIGH;
            end
            TONE_HIGH: begin
                if (load)         state_d = load_ok ? TONE_HIGH : TONE_IDLE;
                else if (cnt_end) state_d = TONE_LOW;
            end
            default: state_d = TONE_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TONE_IDLE;
        else        state_q <= state_d;
    end

    // half-period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || (state_q == TONE_IDLE) || cnt_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end

    // outputs
    always_comb begin
        spk = (state_q == TONE_HIGH);
    end
endmodule

// File: rtl/tone_gen.sv
`timescale 1ns/1ps
module tone_gen
    import tone_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] BANK_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0] NOTE_OFFS = 16'h0024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              spk_out
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = BANK_BASE + NOTE_OFFS;
    localparam int PAD_W = DATA_W - NOTE_W;

    logic              hit;
    logic [NOTE_W-1:0] new_note;
    logic [NOTE_W-1:0] note_q;
    logic [HALF_W-1:0] half;

    tone_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .HIT_ADDR(HIT_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hit     (hit),
        .new_note(new_note),
        .note_q  (note_q)
    );

    tone_lut u_lut (
        .note(note_q),
        .half(half)
    );

    tone_div u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (hit),
        .load_ok(note_ok(new_note)),
        .half   (half),
        .spk    (spk_out)
    );

    assign rd_data = {{PAD_W{1'b0}}, note_q};
endmodule

// File: rtl/tone_gen_chk.sv
`timescale 1ns/1ps
module tone_gen_chk
    import tone_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] HIT_ADDR = 16'h8024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              spk_out
);
    logic hit;
    logic unused_chk_hi;

    assign hit           = wr_en && (wr_addr == HIT_ADDR);
    assign unused_chk_hi = ^wr_data[DATA_W-1:NOTE_W];

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (rd_data[NOTE_W-1:0] == $past(wr_data[NOTE_W-1:0])) &&
                (rd_data[DATA_W-1:NOTE_W] == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(rd_data));

    assert_keep_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && note_ok(wr_data[NOTE_W-1:0])) |=> (spk_out == $past(spk_out)));

    assert_zero_mutes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (wr_data[NOTE_W-1:0] == '0)) |=> !spk_out);

    assert_bad_note_mutes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !note_ok(wr_data[NOTE_W-1:0])) |=> !spk_out);

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !note_ok(rd_data[NOTE_W-1:0])) |=> (!spk_out && $stable(spk_out)));
endmodule

bind tone_gen tone_gen_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .HIT_ADDR(HIT_ADDR)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .spk_out(spk_out)
);

// File: tb/tb_tone_gen.sv
`timescale 1ns/1ps
module tb_tone_gen;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] NOTE_ADDR = 16'h8024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        spk_out;

    tone_gen dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .spk_out(spk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        logic  lvl;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    logic model_lvl = 1'b0;
    logic [7:0] model_note = '0;
    bit   tone_on = 1'b0;
    bit   mon_on = 1'b0;
    logic prev_spk = 1'b0;
    int   last_c0 = 0;
    int   last_h = 0;
    bit   finished = 1'b0;

    function automatic int exp_half(input int n);
        real f;
        f = 440.0 * (2.0 ** (real'(n - 69) / 12.0));
        return $rtoi(6.0e6 / f + 0.5);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every speaker change
    always @(negedge clk) begin : monitor
        exp_t e;
        if (mon_on && (spk_out !== prev_spk)) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected speaker change at cycle %0d actual %0b expected %0b",
                         cyc, spk_out, prev_spk);
            end else begin
                e = q.pop_front();
                if ((e.at != cyc) || (e.lvl !== spk_out)) begin
                    errors++;
                    $display("FAIL %s: speaker edge actual cycle %0d level %0b expected cycle %0d level %0b",
                             e.tag, cyc, spk_out, e.at, e.lvl);
                end
            end
            prev_spk = spk_out;
        end
    end

    // driver: one-cycle write, scoreboard items pushed before the write edge
    task automatic wr(input logic [15:0] a, input logic [31:0] d, input int ntog);
        int   c0;
        int   h;
        bit   hit;
        bit   ok;
        exp_t e;
        @(negedge clk);
        c0  = cyc + 1;
        h   = 0;
        hit = (a == NOTE_ADDR);
        ok  = hit && (d[7:0] >= 8'd60) && (d[7:0] <= 8'd96);
        if (hit) begin
            if (ok) begin
                h = exp_half(int'(d[7:0]));
                for (int k = 1; k <= ntog; k++) begin
                    e.at  = c0 + k * h;
                    e.lvl = ~model_lvl;
                    e.tag = (k > 1) ? "R3" : (tone_on ? "R5" : "R4");
                    q.push_back(e);
                    model_lvl = ~model_lvl;
                end
                tone_on = 1'b1;
            end else begin
                if (model_lvl) begin
                    e.at  = c0;
                    e.lvl = 1'b0;
                    e.tag = (d[7:0] == 8'd0) ? "R6" : "R7";
                    q.push_back(e);
                end
                model_lvl = 1'b0;
                tone_on   = 1'b0;
            end
            model_note = d[7:0];
        end
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(rd_data === {24'd0, model_note}, "R2", "readback", int'(rd_data), int'(model_note));
        last_c0 = c0;
        last_h  = h;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R3: watchdog expired actual cycle %0d expected completion earlier", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(spk_out === 1'b0, "R1", "speaker after reset", int'(spk_out), 0);
        check(rd_data === 32'd0, "R1", "readback after reset", int'(rd_data), 0);
        prev_spk = spk_out;
        mon_on   = 1'b1;

        // R4 then R3: note 69 from silence, three edges
        wr(NOTE_ADDR, 32'd69, 3);
        wait_to(last_c0 + 3 * last_h + 100);

        // R5: highest note written while high
        wr(NOTE_ADDR, 32'd96, 3);
        wait_to(last_c0 + 3 * last_h + 10);

        // R5/R3: lowest note written while low
        wr(NOTE_ADDR, 32'd60, 2);
        wait_to(last_c0 + 2 * last_h + 10);

        wr(NOTE_ADDR, 32'd72, 1);
        wait_to(last_c0 + last_h + 500);

        // R5: reload in mid half-period while high
        wr(NOTE_ADDR, 32'd95, 2);
        wait_to(last_c0 + 2 * last_h + 50);

        // R7: just above range while high
        wr(NOTE_ADDR, 32'd97, 0);
        wait_to(last_c0 + 3000);
        check(spk_out === 1'b0, "R8", "speaker while silent after 97", int'(spk_out), 0);

        // R4 then R6: tone from silence, then zero while high
        wr(NOTE_ADDR, 32'd65, 1);
        wait_to(last_c0 + last_h + 10);
        wr(NOTE_ADDR, 32'd0, 0);
        wait_to(last_c0 + 500);
        check(spk_out === 1'b0, "R6", "speaker after zero", int'(spk_out), 0);

        // R7: just below range from silence
        wr(NOTE_ADDR, 32'd59, 0);
        wait_to(last_c0 + 500);
        check(spk_out === 1'b0, "R7", "speaker after 59", int'(spk_out), 0);

        // R2: neighbouring address is ignored
        wr(16'h8020, 32'd70, 0);
        wait_to(last_c0 + 3000);
        check(rd_data === 32'd59, "R2", "readback after foreign write", int'(rd_data), 59);
        check(spk_out === 1'b0, "R2", "speaker after foreign write", int'(spk_out), 0);

        // R2/R4: upper data bits dropped, low byte 84 plays
        wr(NOTE_ADDR, 32'h0000_0154, 2);
        wait_to(last_c0 + 2 * last_h + 10);

        wr(NOTE_ADDR, 32'd0, 0);
        wait_to(last_c0 + 20);
        check(spk_out === 1'b0, "R6", "speaker at end", int'(spk_out), 0);
        check(q.size() == 0, "R3", "pending speaker edges", q.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule